// File: doc/BRIEF.md
# Protocol Discovery Response Engine

This block answers discovery requests for a mailbox-style data object exchange function. After a one-cycle start strobe it reads two dwords from the request buffer: the length dword and the index dword. If the length is too short for a discovery request, the block rejects the request and writes nothing. Otherwise it looks the index up in a protocol table and writes a three-dword response object into the response buffer. It then pulses done, with a success flag beside it.

The table is a flat input vector of `NUM_PROT` entries. Each entry is 24 bits wide, with the vendor ID in bits [15:0] and the object type in bits [23:16]. The protocol count is `NUM_PROT+1`, because the discovery protocol takes index 0 and table entry k answers index k+1. The discovery protocol uses vendor ID 0x0001 and object type 0x00.

The request buffer is a synchronous RAM. Data requested in one cycle appears in the next.

Top module: `discovery_responder`

## Requirements
- R1: After reset, `done_o`, `ok_o`, `req_rd_o` and `rsp_we_o` are all low.
- R2: A request is rejected when bits [17:0] of request dword 1 hold a value from 1 to 2. The block then writes no response, pulses `done_o` with `ok_o` low, and does so 3 cycles after the cycle in which start was sampled.
- R3: Only bits [17:0] of request dword 1 count as the length. A value of 0 in those bits means 2^18 dwords and is accepted. Bits [31:18] are ignored.
- R4: An accepted request writes response dwords at addresses 0, 1 and 2, one per cycle and in that order. Dword 0 is 0x00000001 (discovery vendor ID 0x0001 in [15:0], type 0x00 in [23:16]) and dword 1 is 3 (the response length).
- R5: Response dword 2 holds the answered vendor ID in [15:0], the object type in [23:16] and the next index in [31:24]. Index 0 answers vendor 0x0001 and type 0x00.
- R6: An index from 1 to `NUM_PROT` answers with table entry index-1.
- R7: An index greater than `NUM_PROT` answers vendor 0xFFFF and type 0xFF.
- R8: The next index is 0 when index+1 equals `NUM_PROT+1`, and index+1 in every other case.
- R9: The index is taken from bits [7:0] of request dword 2. Bits [31:8] are ignored.
- R10: On acceptance, `done_o` rises 7 cycles after start is sampled. It stays high for exactly one cycle, and `ok_o` is high only while `done_o` is high.
- R11: A start strobe seen while a request is in progress, including the done cycle, is ignored. It causes no further reads, writes or done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| req_rd_o | output | 1 | Request buffer read enable |
| req_addr_o | output | ADDR_W | Request buffer dword address |
| req_rdata_i | input | 32 | Request buffer data, valid the cycle after the read |
| proto_tbl_i | input | NUM_PROT*24 | Protocol table, entry k at [24k+23:24k] |
| rsp_we_o | output | 1 | Response buffer write enable |
| rsp_addr_o | output | 2 | Response buffer dword address |
| rsp_wdata_o | output | 32 | Response buffer write data |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Response produced (valid with done_o) |

## Verification
Two events can fall in the same cycle: the completion pulse and a fresh start strobe. The same holds for any cycle of an active request. The bench provokes this by holding start high through a whole transaction, done cycle included. It then lowers start and watches the ports for ten further cycles. It judges the result on two counts: the expected three writes happened, and no fourth write or second done pulse follows.

// File: rtl/discovery_responder.sv
module discovery_responder #(
  parameter int NUM_PROT = 3,
  parameter int ADDR_W = 8,
  parameter logic [15:0] DISC_VID = 16'h0001,
  parameter logic [7:0] DISC_TYPE = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  output logic                     req_rd_o,
  output logic [ADDR_W-1:0]        req_addr_o,
  input  logic [31:0]              req_rdata_i,
  input  logic [NUM_PROT*24-1:0]   proto_tbl_i,
  output logic                     rsp_we_o,
  output logic [1:0]               rsp_addr_o,
  output logic [31:0]              rsp_wdata_o,
  output logic                     done_o,
  output logic                     ok_o
);
  localparam int PCOUNT = NUM_PROT + 1;
  localparam logic [8:0] PCOUNT9 = 9'(PCOUNT);
  localparam int MIN_LEN = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_RLEN, S_CLEN, S_IDX, S_W0, S_W1, S_W2, S_DONE
  } st_t;

  st_t st;
  logic [23:0] ent_q, ent_d;
  logic [7:0]  nxt_q, nxt_d;
  logic        ok_q;

  wire [17:0] len18 = req_rdata_i[17:0];
  wire        len_bad = (len18 != 18'd0) && (len18 < 18'(MIN_LEN));
  wire [7:0]  idx = req_rdata_i[7:0];
  wire        unused_hi = ^req_rdata_i[31:18];

  always_comb begin
    ent_d = 24'hFFFFFF;
    if (idx == 8'd0) begin
      ent_d = {DISC_TYPE, DISC_VID};
    end else begin
      for (int k = 0; k < NUM_PROT; k++)
        if (idx == 8'(k + 1)) ent_d = proto_tbl_i[k*24 +: 24];
    end
    nxt_d = (({1'b0, idx} + 9'd1) == PCOUNT9) ? 8'd0 : idx + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ent_q <= '0;
      nxt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) st <= S_RLEN;
        S_RLEN: st <= S_CLEN;
        S_CLEN: begin
          ok_q <= !len_bad;
          st   <= len_bad ? S_DONE : S_IDX;
        end
        S_IDX: begin
          ent_q <= ent_d;
          nxt_q <= nxt_d;
          st    <= S_W0;
        end
        S_W0:   st <= S_W1;
        S_W1:   st <= S_W2;
        S_W2:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_rd_o   = (st == S_RLEN) || (st == S_CLEN);
  assign req_addr_o = (st == S_RLEN) ? ADDR_W'(1) : ADDR_W'(2);

  assign rsp_we_o   = (st == S_W0) || (st == S_W1) || (st == S_W2);
  assign rsp_addr_o = (st == S_W1) ? 2'd1 : (st == S_W2) ? 2'd2 : 2'd0;

  always_comb begin
    case (st)
      S_W0:    rsp_wdata_o = {8'h00, DISC_TYPE, DISC_VID};
      S_W1:    rsp_wdata_o = 32'(MIN_LEN);
      S_W2:    rsp_wdata_o = {nxt_q, ent_q};
      default: rsp_wdata_o = '0;
    endcase
  end

  assign done_o = (st == S_DONE);
  assign ok_o   = done_o && ok_q;
endmodule

// File: rtl/discovery_responder_chk.sv
module discovery_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_rd_o,
  input logic       rsp_we_o,
  input logic [1:0] rsp_addr_o,
  input logic       done_o,
  input logic       ok_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> done_o);

  // R4
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_we_o && rsp_addr_o == 2'd0) |=> (rsp_we_o && rsp_addr_o == 2'd1));

  // R4
  wr_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_we_o && rsp_addr_o == 2'd2) |=> (done_o && ok_o));

  // R2
  rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd_o && (rsp_we_o || done_o)));
endmodule

bind discovery_responder discovery_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_rd_o(req_rd_o), .rsp_we_o(rsp_we_o),
  .rsp_addr_o(rsp_addr_o), .done_o(done_o), .ok_o(ok_o)
);

// File: tb/discovery_responder_tb_top.sv
module discovery_responder_tb_top;
  localparam int NP = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic req_rd_o;
  logic [7:0] req_addr_o;
  logic [31:0] req_rdata_i = '0;
  logic [NP*24-1:0] tbl;
  logic rsp_we_o;
  logic [1:0] rsp_addr_o;
  logic [31:0] rsp_wdata_o;
  logic done_o, ok_o;

  logic [31:0] req_mem [0:3];
  logic [31:0] rsp_mem [0:3];
  int wcnt = 0;
  int checks = 0;
  int errors = 0;
  bit over = 1'b0;

  assign tbl = {8'h05, 16'h0001, 8'h03, 16'h1E98, 8'h02, 16'h1E98};

  always #5 clk = ~clk;

  discovery_responder #(.NUM_PROT(NP), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_rd_o(req_rd_o),
    .req_addr_o(req_addr_o), .req_rdata_i(req_rdata_i), .proto_tbl_i(tbl),
    .rsp_we_o(rsp_we_o), .rsp_addr_o(rsp_addr_o), .rsp_wdata_o(rsp_wdata_o),
    .done_o(done_o), .ok_o(ok_o)
  );

  always @(posedge clk) begin
    if (req_rd_o) req_rdata_i <= req_mem[req_addr_o[1:0]];
    if (rsp_we_o) begin
      rsp_mem[rsp_addr_o] <= rsp_wdata_o;
      wcnt <= wcnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] len, input logic [31:0] idxdw, output int cyc);
    req_mem[0] = 32'h0000_0001;
    req_mem[1] = len;
    req_mem[2] = idxdw;
    for (int i = 0; i < 4; i++) rsp_mem[i] = 32'hDEAD_BEEF;
    wcnt = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_accept(input string req, input logic [31:0] len, input logic [31:0] idxdw,
                          input logic [31:0] exp_dw2);
    int cyc;
    run(len, idxdw, cyc);
    check({req, " R10 latency"}, cyc, 7);
    check({req, " R10 ok"}, {31'd0, ok_o}, 1);
    check({req, " R4 writes"}, wcnt, 3);
    check({req, " R4 dw0"}, rsp_mem[0], 32'h0000_0001);
    check({req, " R4 dw1"}, rsp_mem[1], 32'd3);
    check({req, " dw2"}, rsp_mem[2], exp_dw2);
    @(negedge clk);
    check({req, " R10 one-cycle done"}, {31'd0, done_o}, 0);
  endtask

  task automatic t_reject(input string req, input logic [31:0] len);
    int cyc;
    run(len, 32'd1, cyc);
    check({req, " R2 latency"}, cyc, 3);
    check({req, " R2 ok low"}, {31'd0, ok_o}, 0);
    check({req, " R2 no writes"}, wcnt, 0);
    @(negedge clk);
    check({req, " R10 one-cycle done"}, {31'd0, done_o}, 0);
  endtask

  task automatic t_busy_start();
    int dn = 0;
    req_mem[1] = 32'd3;
    req_mem[2] = 32'd1;
    wcnt = 0;
    @(negedge clk) start_i = 1'b1;
    for (int i = 0; i < 7; i++) @(negedge clk);
    check("R11 done during held start", {31'd0, done_o}, 1);
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (done_o) dn++;
      @(negedge clk);
    end
    check("R11 writes with held start", wcnt, 3);
    check("R11 extra done pulses", dn, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done after reset", {31'd0, done_o}, 0);
    check("R1 ok after reset", {31'd0, ok_o}, 0);
    check("R1 rd after reset", {31'd0, req_rd_o}, 0);
    check("R1 we after reset", {31'd0, rsp_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_accept("R5 index0", 32'd3, 32'd0, 32'h01_00_0001);
    t_accept("R6 index1", 32'd3, 32'd1, 32'h02_02_1E98);
    t_accept("R6 index2", 32'd4, 32'd2, 32'h03_03_1E98);
    t_accept("R8 last index wraps", 32'd3, 32'd3, 32'h00_05_0001);
    t_accept("R7 index4", 32'd3, 32'd4, 32'h05_FF_FFFF);
    t_accept("R7 index200", 32'd3, 32'd200, 32'hC9_FF_FFFF);
    t_accept("R9 high index bits", 32'd3, 32'hABCD_EF02, 32'h03_03_1E98);
    t_accept("R3 zero length", 32'd0, 32'd1, 32'h02_02_1E98);
    t_accept("R3 high length bits", 32'hFFFC_0003, 32'd1, 32'h02_02_1E98);
    t_reject("R2 length1", 32'd1);
    t_reject("R2 length2", 32'd2);
    t_reject("R3 masked length2", 32'h0004_0002);
    t_busy_start();
    over = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!over) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule